// File: doc/BRIEF.md
# Strobe-Clocked Serial Register Slave

This block is the device side of a four-wire register link that a host drives by toggling general-purpose pins. The host starts every frame by pulsing an active-low clear line. It then shifts an 8-bit header and a 16-bit data word over a strobe line. The header carries a read flag and a register address. In a write, the data word arrives on the data-in line. In a read, the block returns the addressed register on the data-out line. All host wires are asynchronous to the block clock. Each one passes through a two-flop synchroniser, and strobe edges are found from the synchronised samples.

The register file holds two identification words that are read-only, two function-enable words, three GPIO-enable words and three GPIO-direction words. The last eight can be written and read back. Their contents leave the block as flat buses that feed an external pin multiplexer. An enable input decides whether those buses carry the stored values or are forced to all zeros.

The frame controller is a state machine with five states:
- `ST_IDLE`: after reset, waiting for the first clear.
- `ST_HDR`: collecting header bits.
- `ST_WDAT`: collecting write data.
- `ST_RDAT`: returning read data.
- `ST_DONE`: frame finished, waiting for the next clear.

Transitions:
- Clear low sends any state to `ST_HDR` with the bit count at zero.
- The eighth header rising edge moves `ST_HDR` to `ST_RDAT` if the read flag is 1, and to `ST_WDAT` if it is 0.
- The sixteenth data rising edge moves `ST_WDAT` or `ST_RDAT` to `ST_DONE`.

Top module: `strobe_reg_slave`

## Requirements
- R1: While reset is low, every writable register is 0, all three output buses read 0 and data-out is 0.
- R2: The header is 8 bits, most significant bit first, and each bit is sampled on a strobe rising edge. Header bit 7 is the read flag (1 = read, 0 = write) and bits 6:0 are the register address. A read frame changes no register.
- R3: In a write frame, 16 data bits are sampled MSB first on strobe rising edges. The addressed register changes only once the sixteenth bit has been received.
- R4: In a read frame, data-out shows register bit 15 after the first data-phase rising edge and moves to the next lower bit on each later rising edge. The host samples it after each falling edge. Data-out is 0 while a header is being received.
- R5: Address 0x10 reads the platform identifier (default 0x0001), whose low byte is the manufacturer code 0x01.
- R6: Address 0x11 reads the firmware identifier. Its fields are build in bits 15:12, major version in bits 11:8 (always 0), minor version in bits 7:4 and patch in bits 3:0. The default value is 0x3025.
- R7: Addresses 0x20–0x21 (function enable), 0x30–0x32 (GPIO enable) and 0x40–0x42 (GPIO direction) can be written and read back. Register base+i drives bits [16i+15:16i] of its output bus.
- R8: A write to any other address, including 0x10 and 0x11, changes nothing. A read of an unmapped address returns 0x0000.
- R9: Clear low aborts a frame in progress. The partial write is discarded and header counting restarts.
- R10: While the enable input is low, all three output buses read 0. The stored values are kept, can still be read, and can still be written.
- R11: Strobe edges after a frame has completed are ignored until the next clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_en | input | 1 | Enables the register outputs toward the pins |
| host_clr_n | input | 1 | Asynchronous active-low frame clear |
| host_stb | input | 1 | Asynchronous strobe clock from the host |
| host_din | input | 1 | Asynchronous serial data from the host |
| host_dout | output | 1 | Serial read data to the host |
| func_en_o | output | N_FUNC*DW (32) | Function-enable words, gated by pin_en |
| gpio_en_o | output | N_GPIO*DW (48) | GPIO-enable words, gated by pin_en |
| gpio_dir_o | output | N_GPIO*DW (48) | GPIO-direction words, gated by pin_en |

## Verification
The assertions check the following on every cycle:
- a low clear always restarts the header;
- the header count never passes eight;
- data-out stays low during a header;
- the gated buses are zero while the enable is low;
- a writable register changes only in the cycle after a write commits;
- a completed frame stays completed until a clear.

Some behaviour can only be shown by the bench's host-level frames, compared against its behavioural register model. This covers bit ordering, the value returned by each address, the discarding of writes to read-only or unmapped addresses, aborted frames, and stray strobes after a frame.

// File: rtl/strobe_reg_pkg.sv
package strobe_reg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_WDAT,
        ST_RDAT,
        ST_DONE
    } srs_state_e;

    localparam int HDR_BITS = 8;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int           N    = 1,
    parameter logic [N-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] s1, s2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= INIT;
            s2 <= INIT;
        end else begin
            s1 <= d;
            s2 <= s1;
        end
    end

    assign q = s2;
endmodule

// File: rtl/srs_bank.sv
module srs_bank #(
    parameter int DW   = 16,
    parameter int AW   = 7,
    parameter int N    = 2,
    parameter int BASE = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [DW-1:0]   wdata,
    input  logic [AW-1:0]   raddr,
    output logic [DW-1:0]   rdata,
    output logic [N*DW-1:0] q
);
    for (genvar g = 0; g < N; g++) begin : g_reg
        logic [DW-1:0] r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                r <= '0;
            else if (we && waddr == AW'(BASE + g))
                r <= wdata;
        end
        assign q[g*DW +: DW] = r;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++)
            if (raddr == AW'(BASE + i))
                rdata = q[i*DW +: DW];
    end
endmodule

// File: rtl/srs_regfile.sv
module srs_regfile #(
    parameter int          DW          = 16,
    parameter int          AW          = 7,
    parameter int          N_FUNC      = 2,
    parameter int          N_GPIO      = 3,
    parameter int          FUNC_BASE   = 32,
    parameter int          GEN_BASE    = 48,
    parameter int          DIR_BASE    = 64,
    parameter int          PLAT_ADDR   = 16,
    parameter int          FW_ADDR     = 17,
    parameter logic [DW-1:0] PLATFORM_ID = 16'h0001,
    parameter logic [DW-1:0] FW_ID       = 16'h3025
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic [DW-1:0]        wdata,
    input  logic [AW-1:0]        raddr,
    output logic [DW-1:0]        rdata,
    output logic [N_FUNC*DW-1:0] func_q,
    output logic [N_GPIO*DW-1:0] gen_q,
    output logic [N_GPIO*DW-1:0] dir_q
);
    logic [DW-1:0] rd_func, rd_gen, rd_dir, rd_id;

    srs_bank #(.DW(DW), .AW(AW), .N(N_FUNC), .BASE(FUNC_BASE)) u_func (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rd_func), .q(func_q));

    srs_bank #(.DW(DW), .AW(AW), .N(N_GPIO), .BASE(GEN_BASE)) u_gen (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rd_gen), .q(gen_q));

    srs_bank #(.DW(DW), .AW(AW), .N(N_GPIO), .BASE(DIR_BASE)) u_dir (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rd_dir), .q(dir_q));

    always_comb begin
        rd_id = '0;
        if (raddr == AW'(PLAT_ADDR)) rd_id = PLATFORM_ID;
        if (raddr == AW'(FW_ADDR))   rd_id = FW_ID;
    end

    assign rdata = rd_func | rd_gen | rd_dir | rd_id;
endmodule

// File: rtl/strobe_reg_slave.sv
module strobe_reg_slave
    import strobe_reg_pkg::*;
#(
    parameter int         DW          = 16,
    parameter int         AW          = 7,
    parameter int         N_FUNC      = 2,
    parameter int         N_GPIO      = 3,
    parameter logic [15:0] PLATFORM_ID = 16'h0001,
    parameter logic [3:0] FW_BUILD    = 4'h3,
    parameter logic [3:0] FW_MINOR    = 4'h2,
    parameter logic [3:0] FW_PATCH    = 4'h5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pin_en,
    input  logic                 host_clr_n,
    input  logic                 host_stb,
    input  logic                 host_din,
    output logic                 host_dout,
    output logic [N_FUNC*DW-1:0] func_en_o,
    output logic [N_GPIO*DW-1:0] gpio_en_o,
    output logic [N_GPIO*DW-1:0] gpio_dir_o
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [15:0] FW_ID = {FW_BUILD, 4'h0, FW_MINOR, FW_PATCH};

    // synchronised host wires: {clear_n, strobe, data}
    logic [2:0] sync_q;
    logic       clr_s, stb_s, din_s, stb_d, stb_rise;

    srs_sync #(.N(3), .INIT(3'b110)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({host_clr_n, host_stb, host_din}), .q(sync_q));

    assign {clr_s, stb_s, din_s} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_d <= 1'b1;
        else        stb_d <= stb_s;
    end
    assign stb_rise = stb_s & ~stb_d;

    srs_state_e     state_q, state_n;
    logic [CW-1:0]  cnt_q;
    logic [AW-1:0]  hdr_q;
    logic [DW-1:0]  shr_q;
    logic [HDR_BITS-1:0] hdr_next;
    logic           hdr_last, data_last, in_frame, wr_commit;
    logic [DW-1:0]  rd_data;
    logic [N_FUNC*DW-1:0] func_q;
    logic [N_GPIO*DW-1:0] gen_q, dir_q;

    assign hdr_next  = {hdr_q, din_s};
    assign hdr_last  = (state_q == ST_HDR) && stb_rise && (cnt_q == CW'(HDR_BITS - 1));
    assign in_frame  = (state_q == ST_HDR) || (state_q == ST_WDAT) || (state_q == ST_RDAT);
    assign data_last = ((state_q == ST_WDAT) || (state_q == ST_RDAT))
                       && stb_rise && (cnt_q == CW'(DW - 1));
    assign wr_commit = clr_s && data_last && (state_q == ST_WDAT);

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: state_n = ST_IDLE;
            ST_HDR:  if (hdr_last) state_n = hdr_next[HDR_BITS-1] ? ST_RDAT : ST_WDAT;
            ST_WDAT: if (data_last) state_n = ST_DONE;
            ST_RDAT: if (data_last) state_n = ST_DONE;
            ST_DONE: state_n = ST_DONE;
            default: state_n = ST_IDLE;
        endcase
        if (!clr_s) state_n = ST_HDR;
    end

    // state register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            if (!clr_s || hdr_last || data_last)
                cnt_q <= '0;
            else if (stb_rise && in_frame)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // datapath outputs: header, shift register, serial out
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q     <= '0;
            shr_q     <= '0;
            host_dout <= 1'b0;
        end else if (!clr_s) begin
            hdr_q     <= '0;
            host_dout <= 1'b0;
        end else if (stb_rise) begin
            unique case (state_q)
                ST_HDR: begin
                    hdr_q <= hdr_next[AW-1:0];
                    if (hdr_last && hdr_next[HDR_BITS-1])
                        shr_q <= rd_data;
                end
                ST_WDAT: shr_q <= {shr_q[DW-2:0], din_s};
                ST_RDAT: begin
                    host_dout <= shr_q[DW-1];
                    shr_q     <= {shr_q[DW-2:0], 1'b0};
                end
                default: ;
            endcase
        end
    end

    srs_regfile #(
        .DW(DW), .AW(AW), .N_FUNC(N_FUNC), .N_GPIO(N_GPIO),
        .PLATFORM_ID(PLATFORM_ID), .FW_ID(FW_ID)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we(wr_commit), .waddr(hdr_q), .wdata({shr_q[DW-2:0], din_s}),
        .raddr(hdr_next[AW-1:0]), .rdata(rd_data),
        .func_q(func_q), .gen_q(gen_q), .dir_q(dir_q));

    assign func_en_o  = pin_en ? func_q : '0;
    assign gpio_en_o  = pin_en ? gen_q  : '0;
    assign gpio_dir_o = pin_en ? dir_q  : '0;
endmodule

// File: rtl/srs_checker.sv
module srs_checker
    import strobe_reg_pkg::*;
#(
    parameter int DW     = 16,
    parameter int N_FUNC = 2,
    parameter int N_GPIO = 3,
    parameter int CW     = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pin_en,
    input logic                 clr_s,
    input srs_state_e           state_q,
    input logic [CW-1:0]        cnt_q,
    input logic                 host_dout,
    input logic                 wr_commit,
    input logic [N_FUNC*DW-1:0] func_q,
    input logic [N_GPIO*DW-1:0] gen_q,
    input logic [N_GPIO*DW-1:0] dir_q,
    input logic [N_FUNC*DW-1:0] func_en_o,
    input logic [N_GPIO*DW-1:0] gpio_en_o,
    input logic [N_GPIO*DW-1:0] gpio_dir_o
);
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (func_en_o == '0 && gpio_en_o == '0 && gpio_dir_o == '0 && !host_dout));

    a_r2_hdr_count: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HDR |-> cnt_q < CW'(HDR_BITS));

    a_r3_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
        (func_q != $past(func_q) || gen_q != $past(gen_q) || dir_q != $past(dir_q))
        |-> $past(wr_commit));

    a_r4_dout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HDR |-> !host_dout);

    a_r9_clear_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_s |=> (state_q == ST_HDR && cnt_q == '0));

    a_r10_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_en |-> (func_en_o == '0 && gpio_en_o == '0 && gpio_dir_o == '0));

    a_r11_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && clr_s) |=> (state_q == ST_DONE && $stable(host_dout)));
endmodule

bind strobe_reg_slave srs_checker #(
    .DW(DW), .N_FUNC(N_FUNC), .N_GPIO(N_GPIO), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pin_en(pin_en), .clr_s(clr_s),
    .state_q(state_q), .cnt_q(cnt_q), .host_dout(host_dout),
    .wr_commit(wr_commit), .func_q(func_q), .gen_q(gen_q), .dir_q(dir_q),
    .func_en_o(func_en_o), .gpio_en_o(gpio_en_o), .gpio_dir_o(gpio_dir_o)
);

// File: tb/tb_strobe_reg_slave.sv
`timescale 1ns/1ps
module tb_strobe_reg_slave;
    localparam int HOLD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_en = 1'b1;
    logic host_clr_n = 1'b1;
    logic host_stb = 1'b1;
    logic host_din = 1'b0;
    logic host_dout;
    logic [31:0] func_en_o;
    logic [47:0] gpio_en_o, gpio_dir_o;

    int n_tests = 0;
    int n_fail = 0;
    bit busy = 1'b1;
    bit finished = 1'b0;
    logic [15:0] mdl [0:127];
    logic [15:0] rv;

    always #4 clk = ~clk;

    strobe_reg_slave dut (
        .clk(clk), .rst_n(rst_n), .pin_en(pin_en), .host_clr_n(host_clr_n),
        .host_stb(host_stb), .host_din(host_din), .host_dout(host_dout),
        .func_en_o(func_en_o), .gpio_en_o(gpio_en_o), .gpio_dir_o(gpio_dir_o));

    function automatic bit writable(logic [6:0] a);
        return (a >= 7'h20 && a <= 7'h21) || (a >= 7'h30 && a <= 7'h32) ||
               (a >= 7'h40 && a <= 7'h42);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 128; i++) mdl[i] = 16'h0000;
        mdl[7'h10] = 16'h0001;
        mdl[7'h11] = 16'h3025;
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-clock comparison of the pin buses against the model (R7, R10)
    always @(posedge clk) begin
        #2;
        if (rst_n && !busy && !finished) begin
            chk("R7/R10 func pins", {32'h0, func_en_o},
                pin_en ? {32'h0, mdl[7'h21], mdl[7'h20]} : 64'h0);
            chk("R7/R10 gpio en pins", {16'h0, gpio_en_o},
                pin_en ? {16'h0, mdl[7'h32], mdl[7'h31], mdl[7'h30]} : 64'h0);
            chk("R7/R10 gpio dir pins", {16'h0, gpio_dir_o},
                pin_en ? {16'h0, mdl[7'h42], mdl[7'h41], mdl[7'h40]} : 64'h0);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_pulse();
        host_clr_n = 1'b0; idle(HOLD);
        host_clr_n = 1'b1; idle(HOLD);
    endtask

    task automatic send_header(bit rd, logic [6:0] a, int nbits);
        logic [7:0] h;
        h = {rd, a};
        for (int k = 0; k < nbits; k++) begin
            host_stb = 1'b0; host_din = h[7-k]; idle(HOLD);
            host_stb = 1'b1; idle(HOLD);
        end
        host_stb = 1'b0; idle(HOLD);
    endtask

    task automatic wr_frame(logic [6:0] a, logic [15:0] v, int nbits);
        busy = 1'b1;
        clear_pulse();
        send_header(1'b0, a, 8);
        for (int k = 0; k < nbits; k++) begin
            host_din = v[15-k]; idle(HOLD);
            host_stb = 1'b1;    idle(HOLD);
            host_stb = 1'b0;    idle(HOLD);
        end
        if (nbits == 16) begin
            host_stb = 1'b1; idle(HOLD);
            if (writable(a)) mdl[a] = v;
            busy = 1'b0;
        end
    endtask

    task automatic rd_frame(logic [6:0] a, output logic [15:0] v);
        busy = 1'b1;
        clear_pulse();
        send_header(1'b1, a, 8);
        for (int k = 0; k < 16; k++) begin
            host_stb = 1'b1; idle(HOLD);
            host_stb = 1'b0; idle(HOLD);
            v[15-k] = host_dout;
        end
        host_stb = 1'b1; idle(HOLD);
        busy = 1'b0;
    endtask

    initial begin
        idle(150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        idle(5);
        // R1: reset state
        chk("R1 func pins", {32'h0, func_en_o}, 64'h0);
        chk("R1 gpio pins", {gpio_en_o, 16'h0}, 64'h0);
        chk("R1 dir pins", {16'h0, gpio_dir_o}, 64'h0);
        chk("R1 dout", {63'h0, host_dout}, 64'h0);
        rst_n = 1'b1; idle(5);
        busy = 1'b0;

        // R5, R6: identification registers
        rd_frame(7'h10, rv);
        chk("R5 platform id", {48'h0, rv}, 64'h0001);
        chk("R5 manufacturer byte", {56'h0, rv[7:0]}, 64'h01);
        rd_frame(7'h11, rv);
        chk("R6 firmware id", {48'h0, rv}, 64'h3025);
        chk("R6 major zero", {60'h0, rv[11:8]}, 64'h0);

        // R3, R4, R7: write then read back every writable register
        wr_frame(7'h20, 16'hA5C3, 16);
        chk("R3 func pins after write", {32'h0, func_en_o}, {32'h0, 16'h0, 16'hA5C3});
        rd_frame(7'h20, rv);
        chk("R4 read back 0x20", {48'h0, rv}, 64'hA5C3);
        wr_frame(7'h21, 16'h1234, 16);
        wr_frame(7'h30, 16'h8001, 16);
        wr_frame(7'h31, 16'h7FFE, 16);
        wr_frame(7'h32, 16'h0F0F, 16);
        wr_frame(7'h40, 16'hF00D, 16);
        wr_frame(7'h41, 16'hBEEF, 16);
        wr_frame(7'h42, 16'h0001, 16);
        for (int a = 0; a < 128; a++) begin
            if (writable(7'(a))) begin
                rd_frame(7'(a), rv);
                chk("R7/R2 read back", {48'h0, rv}, {48'h0, mdl[a]});
            end
        end

        // R8: writes to read-only and unmapped addresses are dropped
        wr_frame(7'h10, 16'hFFFF, 16);
        wr_frame(7'h11, 16'hFFFF, 16);
        wr_frame(7'h55, 16'hABCD, 16);
        wr_frame(7'h22, 16'h1111, 16);
        rd_frame(7'h10, rv);
        chk("R8 platform id kept", {48'h0, rv}, 64'h0001);
        rd_frame(7'h11, rv);
        chk("R8 firmware id kept", {48'h0, rv}, 64'h3025);
        rd_frame(7'h55, rv);
        chk("R8 unmapped 0x55 reads 0", {48'h0, rv}, 64'h0);
        rd_frame(7'h22, rv);
        chk("R8 unmapped 0x22 reads 0", {48'h0, rv}, 64'h0);
        rd_frame(7'h43, rv);
        chk("R8 unmapped 0x43 reads 0", {48'h0, rv}, 64'h0);

        // R9: abort a write after 10 data bits, and a header after 4 bits
        wr_frame(7'h30, 16'h5555, 10);
        clear_pulse();
        busy = 1'b0;
        idle(4);
        rd_frame(7'h30, rv);
        chk("R9 aborted write discarded", {48'h0, rv}, 64'h8001);
        busy = 1'b1;
        clear_pulse();
        send_header(1'b0, 7'h7F, 4);
        wr_frame(7'h31, 16'h2222, 16);
        rd_frame(7'h31, rv);
        chk("R9 header restarts after clear", {48'h0, rv}, 64'h2222);

        // R10: enable low gates outputs but keeps storage
        pin_en = 1'b0; idle(2);
        chk("R10 pins gated", {16'h0, gpio_dir_o}, 64'h0);
        rd_frame(7'h40, rv);
        chk("R10 stored value readable", {48'h0, rv}, 64'hF00D);
        wr_frame(7'h42, 16'hAAAA, 16);
        pin_en = 1'b1; idle(2);
        chk("R10 write while disabled", {48'h0, gpio_dir_o[47:32]}, 64'hAAAA);

        // R11: stray strobes after a completed frame
        wr_frame(7'h21, 16'h00FF, 16);
        busy = 1'b0;
        host_din = 1'b1;
        for (int k = 0; k < 20; k++) begin
            host_stb = 1'b0; idle(HOLD);
            host_stb = 1'b1; idle(HOLD);
        end
        chk("R11 func pins unchanged", {32'h0, func_en_o}, {32'h0, 16'h00FF, 16'hA5C3});
        rd_frame(7'h21, rv);
        chk("R11 read back after stray strobes", {48'h0, rv}, 64'h00FF);

        // R1: reset during operation
        busy = 1'b1;
        rst_n = 1'b0;
        model_reset();
        idle(3);
        chk("R1 mid-run reset func", {32'h0, func_en_o}, 64'h0);
        chk("R1 mid-run reset dir", {16'h0, gpio_dir_o}, 64'h0);
        rst_n = 1'b1; idle(4);
        busy = 1'b0;
        rd_frame(7'h41, rv);
        chk("R1 register zero after reset", {48'h0, rv}, 64'h0);

        finished = 1'b1;
        idle(2);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule